// File: doc/BRIEF.md
# Chained-Segment Byte FIFO

This block is a byte-wide first-in-first-out buffer for a sampling front end. Its storage is a ring of identical segments, so the total capacity is the number of segments times the depth of one segment. Each segment owns a slice of storage, its own write and read offsets, its own occupancy count and its own full and empty indications. A write token and a read token travel around the ring. Only the segment holding the write token stores incoming bytes. When its last slot is written, it hands the write token to the next segment. The read token moves the same way on the read side. Bytes therefore come out in the order they went in, across every segment boundary and across wrap-around.

Samples come from a converter whose conversion-done line is active low. Each high-to-low transition of that line stores one byte. A controller pulls bytes out with a level read request, one byte per clock. The block reports an overall active-low full flag, an overall active-low empty flag and an active-low full flag for each segment. The whole block runs on one clock, and all strobes are synchronous to it. The default build has eight segments of 512 bytes. Setting the segment depth to 4096 gives the larger build.

Top module: `chain_fifo`

## Requirements
- R1: While reset is held low, and after it is released, `empty_n` is 0, `full_n` is 1, every bit of `seg_full_n` is 1 and `rd_data` is 0. Both tokens sit in segment 0, and all other segments start without tokens.
- R2: A byte is stored on the clock edge where `conv_done_n` is first sampled 0 after being sampled 1. Holding `conv_done_n` low for several cycles stores exactly one byte.
- R3: Bytes are returned in the order they were stored, across segment boundaries and across wrap from the last segment back to segment 0. `rd_data` takes the byte on the clock edge that accepts the read and holds it until the next accepted read.
- R4: `full_n` is 0 exactly when SEG_COUNT*SEG_DEPTH bytes are held. A conversion-done pulse that arrives while `full_n` is 0 stores nothing, and the held contents stay unchanged.
- R5: `empty_n` is 0 exactly when no byte is held. A read request while `empty_n` is 0 leaves `rd_data` and all occupancy unchanged.
- R6: `seg_full_n[k]` is 0 exactly when segment k holds SEG_DEPTH bytes. From reset, segment 0 fills first, then segment 1, and so on in index order.
- R7: A read and a write accepted in the same cycle both take effect, so the number of bytes held stays the same. Acceptance is judged on the flags before that edge.
- R8: Exactly one segment holds the write token and exactly one holds the read token at all times. A token moves only on a cycle in which an access of its kind is accepted.
- R9: `full_n` and `empty_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done_n | input | 1 | Active-low conversion-done strobe; each falling transition stores one byte |
| sample_i | input | DATA_W | Byte presented with the strobe |
| rd_req | input | 1 | Read request, one byte per cycle while high and not empty |
| rd_data | output | DATA_W | Last byte read, registered |
| empty_n | output | 1 | Active-low overall empty flag |
| full_n | output | 1 | Active-low overall full flag |
| seg_full_n | output | SEG_COUNT | Active-low full flag of each segment |

## Verification
Every result of this block is due on the same rising edge that accepts the access. `full_n`, `empty_n`, `seg_full_n` and `rd_data` all change on the edge where the strobe is first seen low or the read is accepted, with no further pipeline stage. The bench drives inputs just after a falling edge and lets one rising edge pass. At that edge it updates its occupancy model from the pre-edge flags. It compares all four outputs at the next falling edge, a half period after the edge that should have changed them. Because of this, a one-cycle bubble or an early flag move in the design shows up as a miscompare in that same cycle.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

  // index of the ring neighbour that feeds tokens into segment idx
  function automatic int ring_prev(input int idx, input int n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // bits needed to address n slots (at least one bit)
  function automatic int addr_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // bits needed to count 0..n inclusive
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cf_strobe_edge.sv
module cf_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_o
);
  logic prev_q;

  // idle level of the strobe is high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fall_o = prev_q & ~strobe_n;
endmodule

// File: rtl/cf_segment.sv
module cf_segment #(
  parameter int DATA_W    = 8,
  parameter int SEG_DEPTH = 512,
  parameter bit IS_FIRST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire_i,
  input  logic              rd_fire_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              wr_tok_i,
  input  logic              rd_tok_i,
  output logic              wr_own_o,
  output logic              rd_own_o,
  output logic              wr_pass_o,
  output logic              rd_pass_o,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int OFF_W = chain_fifo_pkg::addr_bits(SEG_DEPTH);
  localparam int CNT_W = chain_fifo_pkg::count_bits(SEG_DEPTH);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SEG_DEPTH);

  logic [DATA_W-1:0] store_q [SEG_DEPTH];
  logic [OFF_W-1:0]  wr_off_q, rd_off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_own_q, rd_own_q;
  logic              wr_hit, rd_hit;

  assign wr_hit    = wr_fire_i & wr_own_q;
  assign rd_hit    = rd_fire_i & rd_own_q;
  assign wr_pass_o = wr_hit & (wr_off_q == LAST_OFF);
  assign rd_pass_o = rd_hit & (rd_off_q == LAST_OFF);

  always_ff @(posedge clk) begin
    if (wr_hit) store_q[wr_off_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off_q <= '0;
      rd_off_q <= '0;
      cnt_q    <= '0;
      wr_own_q <= IS_FIRST;
      rd_own_q <= IS_FIRST;
    end else begin
      if (wr_hit) wr_off_q <= wr_pass_o ? '0 : wr_off_q + 1'b1;
      if (rd_hit) rd_off_q <= rd_pass_o ? '0 : rd_off_q + 1'b1;
      case ({wr_hit, rd_hit})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      // an incoming token wins over the outgoing one (single-segment ring)
      wr_own_q <= wr_tok_i | (wr_own_q & ~wr_pass_o);
      rd_own_q <= rd_tok_i | (rd_own_q & ~rd_pass_o);
    end
  end

  assign wr_own_o  = wr_own_q;
  assign rd_own_o  = rd_own_q;
  assign rd_word_o = store_q[rd_off_q];
  assign full_o    = (cnt_q == FULL_CNT);
  assign empty_o   = (cnt_q == '0);
endmodule

// File: rtl/cf_read_select.sv
module cf_read_select #(
  parameter int DATA_W    = 8,
  parameter int SEG_COUNT = 8
) (
  input  logic [SEG_COUNT-1:0]        own_i,
  input  logic [SEG_COUNT*DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]           word_o
);
  // AND-OR select: exactly one owner is set
  always_comb begin
    word_o = '0;
    for (int k = 0; k < SEG_COUNT; k++) begin
      word_o = word_o | (words_i[k*DATA_W +: DATA_W] & {DATA_W{own_i[k]}});
    end
  end
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int DATA_W    = 8,
  parameter int SEG_COUNT = 8,
  parameter int SEG_DEPTH = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done_n,
  input  logic [DATA_W-1:0]    sample_i,
  input  logic                 rd_req,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 empty_n,
  output logic                 full_n,
  output logic [SEG_COUNT-1:0] seg_full_n
);
  localparam int WORDS_W = SEG_COUNT * DATA_W;

  // named internal events, visible to the bound checker
  logic                 wr_edge;
  logic                 wr_fire;
  logic                 rd_fire;
  logic [SEG_COUNT-1:0] wr_tok_vec, rd_tok_vec;
  logic [SEG_COUNT-1:0] wr_pass_vec, rd_pass_vec;
  logic [SEG_COUNT-1:0] seg_full, seg_empty;
  logic [WORDS_W-1:0]   seg_words;
  logic [DATA_W-1:0]    sel_word;
  logic [DATA_W-1:0]    rd_data_q;

  cf_strobe_edge strobe_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (conv_done_n),
    .fall_o   (wr_edge)
  );

  assign wr_fire = wr_edge & full_n;
  assign rd_fire = rd_req & empty_n;

  for (genvar k = 0; k < SEG_COUNT; k++) begin : g_seg
    localparam int PREV = chain_fifo_pkg::ring_prev(k, SEG_COUNT);
    cf_segment #(
      .DATA_W    (DATA_W),
      .SEG_DEPTH (SEG_DEPTH),
      .IS_FIRST  (k == 0)
    ) seg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_fire_i (wr_fire),
      .rd_fire_i (rd_fire),
      .din_i     (sample_i),
      .wr_tok_i  (wr_pass_vec[PREV]),
      .rd_tok_i  (rd_pass_vec[PREV]),
      .wr_own_o  (wr_tok_vec[k]),
      .rd_own_o  (rd_tok_vec[k]),
      .wr_pass_o (wr_pass_vec[k]),
      .rd_pass_o (rd_pass_vec[k]),
      .rd_word_o (seg_words[k*DATA_W +: DATA_W]),
      .full_o    (seg_full[k]),
      .empty_o   (seg_empty[k])
    );
    assign seg_full_n[k] = ~seg_full[k];
  end

  cf_read_select #(
    .DATA_W    (DATA_W),
    .SEG_COUNT (SEG_COUNT)
  ) rsel_i (
    .own_i   (rd_tok_vec),
    .words_i (seg_words),
    .word_o  (sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_q <= '0;
    else if (rd_fire) rd_data_q <= sel_word;
  end

  assign rd_data = rd_data_q;
  assign full_n  = ~(&seg_full);
  assign empty_n = ~(&seg_empty);
endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
  parameter int SEG_COUNT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 full_n,
  input logic                 empty_n,
  input logic                 wr_fire,
  input logic                 rd_fire,
  input logic [SEG_COUNT-1:0] wr_tok_vec,
  input logic [SEG_COUNT-1:0] rd_tok_vec
);
  // R8
  wr_tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_tok_vec) == 1);
  // R8
  rd_tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_tok_vec) == 1);
  // R8
  wr_tok_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_tok_vec));
  // R8
  rd_tok_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_tok_vec));
  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rd_fire) |=> !full_n);
  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !wr_fire) |=> !empty_n);
  // R7
  both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> ($stable(full_n) && $stable(empty_n)));
  // R9
  flags_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n));
endmodule

bind chain_fifo chain_fifo_chk #(.SEG_COUNT(SEG_COUNT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .full_n     (full_n),
  .empty_n    (empty_n),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire),
  .wr_tok_vec (wr_tok_vec),
  .rd_tok_vec (rd_tok_vec)
);

// File: tb/chain_fifo_tb.sv
`timescale 1ns/1ps
module chain_fifo_tb_top;
  localparam int DW  = 8;
  localparam int SC  = 4;
  localparam int SD  = 4;
  localparam int CAP = SC * SD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_done_n = 1'b1;
  logic [DW-1:0] sample_i = '0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_data;
  logic          empty_n, full_n;
  logic [SC-1:0] seg_full_n;

  int unsigned vectors = 0;
  int unsigned errors = 0;

  // reference model state
  logic [DW-1:0] m_mem [CAP];
  int            m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [DW-1:0] m_rd = '0;
  logic          m_prev_cd = 1'b1;

  always #4 clk = ~clk;

  chain_fifo #(.DATA_W(DW), .SEG_COUNT(SC), .SEG_DEPTH(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done_n(conv_done_n), .sample_i(sample_i),
    .rd_req(rd_req), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
    .seg_full_n(seg_full_n)
  );

  function automatic logic [SC-1:0] exp_seg_full_n(input int rp, input int cnt);
    logic [SC-1:0] r;
    for (int k = 0; k < SC; k++) begin
      int n = 0;
      for (int i = 0; i < cnt; i++) if (((rp + i) % CAP) / SD == k) n++;
      r[k] = (n == SD) ? 1'b0 : 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4 full_n", 32'(full_n), 32'(m_cnt != CAP));
    check("R5 empty_n", 32'(empty_n), 32'(m_cnt != 0));
    check("R6 seg_full_n", 32'(seg_full_n), 32'(exp_seg_full_n(m_rp, m_cnt)));
    check("R3 rd_data", 32'(rd_data), 32'(m_rd));
  endtask

  // drive after a falling edge, model at the rising edge, compare at the next falling edge
  task automatic cyc(input logic cd, input logic rd);
    bit wr_ok, rd_ok;
    conv_done_n = cd;
    rd_req      = rd;
    sample_i    = DW'($urandom);
    @(posedge clk);
    wr_ok = m_prev_cd && !cd && (m_cnt < CAP);
    rd_ok = rd && (m_cnt > 0);
    if (rd_ok) begin
      m_rd = m_mem[m_rp];
      m_rp = (m_rp + 1) % CAP;
    end
    if (wr_ok) begin
      m_mem[m_wp] = sample_i;
      m_wp = (m_wp + 1) % CAP;
    end
    m_cnt = m_cnt + int'(wr_ok) - int'(rd_ok);
    m_prev_cd = cd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    check("R1 empty_n", 32'(empty_n), 32'd0);
    check("R1 full_n", 32'(full_n), 32'd1);
    check("R1 seg_full_n", 32'(seg_full_n), 32'((1 << SC) - 1));
    check("R1 rd_data", 32'(rd_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: strobe held low stores one byte only
    repeat (5) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    check("R2 one byte held", 32'(empty_n), 32'd1);
    cyc(1'b1, 1'b1);
    check("R2 drained after one read", 32'(empty_n), 32'd0);

    // R6, R4: fill segment by segment, then extra pulses while full
    for (int i = 0; i < CAP + 3; i++) begin
      cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
    end
    check("R4 full after capacity", 32'(full_n), 32'd0);

    // R7: write rejected at full while read accepted
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    check("R7 one slot free", 32'(full_n), 32'd1);
    cyc(1'b0, 1'b1);
    check("R7 read+write keep level", 32'(full_n), 32'd1);
    cyc(1'b1, 1'b0);

    // R3, R5: drain across all segments, then reads on empty
    repeat (CAP + 3) cyc(1'b1, 1'b1);
    check("R5 empty after drain", 32'(empty_n), 32'd0);

    // R7: read rejected at empty while write accepted
    cyc(1'b0, 1'b1);
    check("R7 write at empty", 32'(empty_n), 32'd1);
    cyc(1'b1, 1'b0);

    // random phases: write-heavy and read-heavy, wrapping the ring (R3, R8)
    for (int ph = 0; ph < 20; ph++) begin
      int wp = (ph % 2 == 0) ? 70 : 30;
      int rp = (ph % 2 == 0) ? 25 : 75;
      for (int i = 0; i < 200; i++)
        cyc(($urandom % 100) < wp ? 1'b0 : 1'b1, ($urandom % 100) < rp);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule